// File: doc/BRIEF.md
# Iterative Signed Non-Restoring Divider

This block divides one 32-bit two's complement integer by another and returns both the quotient and the remainder, as a processor's integer divide instruction needs. It works sequentially. A start pulse captures the operands. The block then performs a single non-restoring step each clock on the operand magnitudes, and it spends one more cycle on the final correction and on the result signs.

While the computation runs, the block holds `stall` high. The surrounding pipeline uses that level to freeze its program counter. When `stall` drops, the new quotient and remainder are already on the outputs, and they stay there until the next division completes. The quotient truncates toward zero, and the remainder carries the sign of the dividend. The block raises no error flag. Division by zero and the most-negative-by-minus-one case each give a fixed result.

Top module: `sdiv_nr`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `stall` is 0 and `quotient` and `remainder` are both 0.
- R2: When `start` is sampled high while `stall` is 0, `stall` goes high on that same clock edge. It then stays high for exactly W+1 = 33 clock cycles before returning to 0.
- R3: When `stall` falls, `quotient` equals the dividend divided by the divisor truncated toward zero, and `remainder` equals dividend − quotient × divisor. The remainder is either zero or has the sign of the dividend. The magnitude of the remainder is below the magnitude of the divisor. For example, 42/13 gives 3 rem 3, −42/13 gives −3 rem −3, 42/−13 gives −3 rem 3, and −42/−13 gives 3 rem −3.
- R4: R3 holds for operands of large magnitude and for arbitrary bit patterns in both operands.
- R5: A `start` that arrives while `stall` is 1 is ignored. The running division finishes with the operands captured at its own start, and no second division follows the ignored pulse.
- R6: 0x80000000 divided by 0xFFFFFFFF (−1) gives quotient 0x80000000 and remainder 0.
- R7: A divisor of 0 completes in the normal 33 cycles and gives remainder = dividend. The quotient is 0xFFFFFFFF when the dividend is non-negative and 0x00000001 when it is negative.
- R8: `quotient` and `remainder` change only on the edge where `stall` falls. At all other times they hold the last result.
- R9: While `stall` is 0 and `start` stays 0, `stall` remains 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division; accepted only when `stall` is 0 |
| dividend | input | 32 | Signed dividend, captured on an accepted start |
| divisor | input | 32 | Signed divisor, captured on an accepted start |
| quotient | output | 32 | Registered signed quotient of the last completed division |
| remainder | output | 32 | Registered signed remainder of the last completed division |
| stall | output | 1 | High from the accepted start until the results are valid |

## Verification
The assertions take for granted that the operands only matter on the edge where a start is accepted. They also assume that `rst` is applied from time zero, so the shadow copy of the operands in the checker lines up with the division that the block really runs. The stimulus drives `start` and the operands only on falling edges and holds each pulse for one cycle. It waits for `stall` to drop before it sends the next real division. The ignored-start case is sent deliberately in the middle of a running division, with operands that differ from the captured ones. The expected results are tracked only for accepted starts, so any relatching of the ignored operands would show up as a mismatch.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_sign_prep.sv
module sdiv_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] num_mag,
  output logic [W-1:0] den_mag,
  output logic         num_neg,
  output logic         den_neg
);
  assign num_neg = num[W-1];
  assign den_neg = den[W-1];
  // magnitudes are unsigned, so the most negative value maps to 2^(W-1)
  assign num_mag = num_neg ? (~num + 1'b1) : num;
  assign den_mag = den_neg ? (~den + 1'b1) : den;
endmodule

// File: rtl/sdiv_nr_step.sv
module sdiv_nr_step #(
  parameter int W = 32
) (
  input  logic [W:0]   part_in,
  input  logic [W-1:0] shreg_in,
  input  logic [W-1:0] den_mag,
  output logic [W:0]   part_out,
  output logic [W-1:0] shreg_out
);
  logic [W:0] shifted;
  logic [W:0] den_ext;

  always_comb begin
    shifted = {part_in[W-1:0], shreg_in[W-1]};
    den_ext = {1'b0, den_mag};
    // a negative partial remainder adds the divisor back, otherwise subtract
    if (part_in[W]) part_out = shifted + den_ext;
    else            part_out = shifted - den_ext;
    shreg_out = {shreg_in[W-2:0], ~part_out[W]};
  end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
  parameter int W = 32
) (
  input  logic [W:0]   part,
  input  logic [W-1:0] den_mag,
  input  logic [W-1:0] quo_mag,
  input  logic         quo_neg,
  input  logic         rem_neg,
  output logic [W-1:0] quo_res,
  output logic [W-1:0] rem_res
);
  logic [W-1:0] rem_mag;

  always_comb begin
    // the low W bits suffice: the corrected remainder lies in [0, divisor)
    rem_mag = part[W-1:0] + (part[W] ? den_mag : '0);
    quo_res = quo_neg ? (~quo_mag + 1'b1) : quo_mag;
    rem_res = rem_neg ? (~rem_mag + 1'b1) : rem_mag;
  end
endmodule

// File: rtl/sdiv_nr.sv
module sdiv_nr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         stall
);
  import sdiv_pkg::*;

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  sdiv_state_e  state_q;
  logic [CW-1:0] step_q;
  logic [W:0]   part_q;
  logic [W-1:0] shreg_q;
  logic [W-1:0] den_q;
  logic         quo_neg_q;
  logic         rem_neg_q;

  logic [W-1:0] num_mag, den_mag;
  logic         num_neg, den_neg;
  logic [W:0]   part_nx;
  logic [W-1:0] shreg_nx;
  logic [W-1:0] quo_res, rem_res;

  sdiv_sign_prep #(.W(W)) u_prep (
    .num     (dividend),
    .den     (divisor),
    .num_mag (num_mag),
    .den_mag (den_mag),
    .num_neg (num_neg),
    .den_neg (den_neg)
  );

  sdiv_nr_step #(.W(W)) u_step (
    .part_in   (part_q),
    .shreg_in  (shreg_q),
    .den_mag   (den_q),
    .part_out  (part_nx),
    .shreg_out (shreg_nx)
  );

  sdiv_fixup #(.W(W)) u_fix (
    .part    (part_q),
    .den_mag (den_q),
    .quo_mag (shreg_q),
    .quo_neg (quo_neg_q),
    .rem_neg (rem_neg_q),
    .quo_res (quo_res),
    .rem_res (rem_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      part_q    <= '0;
      shreg_q   <= '0;
      den_q     <= '0;
      quo_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      stall     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            part_q    <= '0;
            shreg_q   <= num_mag;
            den_q     <= den_mag;
            quo_neg_q <= num_neg ^ den_neg;
            rem_neg_q <= num_neg;
            step_q    <= '0;
            stall     <= 1'b1;
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          part_q  <= part_nx;
          shreg_q <= shreg_nx;
          step_q  <= step_q + 1'b1;
          if (step_q == LAST_STEP) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quotient  <= quo_res;
          remainder <= rem_res;
          stall     <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdiv_nr_chk.sv
module sdiv_nr_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         stall
);
  localparam int KW = $clog2(W + 2) + 1;

  logic [W-1:0]  lat_a, lat_b;
  logic [KW-1:0] busy_cnt;
  logic [W-1:0]  low_prod, rem_abs, den_abs;
  logic          arith_ok, zero_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a    <= '0;
      lat_b    <= '0;
      busy_cnt <= '0;
    end else begin
      if (start && !stall) begin
        lat_a <= dividend;
        lat_b <= divisor;
      end
      if (stall) busy_cnt <= busy_cnt + 1'b1;
      else       busy_cnt <= '0;
    end
  end

  always_comb begin
    low_prod = quotient * lat_b;
    rem_abs  = remainder[W-1] ? (~remainder + 1'b1) : remainder;
    den_abs  = lat_b[W-1] ? (~lat_b + 1'b1) : lat_b;
    arith_ok = (low_prod + remainder == lat_a) && (rem_abs < den_abs) &&
               ((remainder == '0) || (remainder[W-1] == lat_a[W-1]));
    zero_ok  = (remainder == lat_a) &&
               (quotient == (lat_a[W-1] ? W'(1) : '1));
  end

  // R1
  a_reset_state_r1: assert property (@(posedge clk)
    $fell(rst) |-> !stall && quotient == '0 && remainder == '0);

  p_stall_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !stall) |=> stall);

  p_stall_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> busy_cnt == KW'(W + 1));

  p_result_arith_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(stall) && lat_b != '0) |-> arith_ok);

  p_div_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(stall) && lat_b == '0) |-> zero_ok);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$fell(stall) |-> ($stable(quotient) && $stable(remainder)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!stall && !start) |=> !stall);
endmodule

bind sdiv_nr sdiv_nr_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .quotient  (quotient),
  .remainder (remainder),
  .stall     (stall)
);

// File: tb/sdiv_nr_test.sv
`timescale 1ns/1ps
module sdiv_nr_test;
  localparam int W = 32;
  localparam int BUSY = W + 1;

  typedef struct {
    logic [31:0] a, b, q, r;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] quotient, remainder;
  logic        stall;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  exp_t sb[$];
  logic [31:0] last_q = '0, last_r = '0;

  always #2.5 clk = ~clk;

  sdiv_nr #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .stall(stall)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input string tag);
    exp_t e;
    int sa, sb_;
    e.a = a; e.b = b; e.tag = tag;
    sa = int'(a); sb_ = int'(b);
    if (b == 32'd0) begin
      e.q = a[31] ? 32'd1 : 32'hFFFF_FFFF;
      e.r = a;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      e.q = 32'h8000_0000;
      e.r = 32'd0;
    end else begin
      e.q = 32'(sa / sb_);
      e.r = 32'(sa % sb_);
    end
    return e;
  endfunction

  task automatic do_div(input logic [31:0] a, input logic [31:0] b,
                        input string tag);
    @(negedge clk);
    while (stall) @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    sb.push_back(model(a, b, tag));
    @(negedge clk);
    start = 1'b0;
    chk(stall == 1'b1, "R2", "stall after accepted start", {31'd0, stall}, 32'd1);
  endtask

  // monitor: counts busy cycles and compares results at completion
  int busy_n = 0;
  logic stall_d = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stall) busy_n++;
      if (stall_d && !stall) begin
        chk(busy_n == BUSY, "R2", "stall length", 32'(busy_n), 32'(BUSY));
        if (sb.size() == 0) begin
          chk(1'b0, "R5", "unexpected completion", quotient, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(quotient == e.q, e.tag, "quotient", quotient, e.q);
          chk(remainder == e.r, e.tag, "remainder", remainder, e.r);
          last_q = e.q; last_r = e.r;
        end
        busy_n = 0;
      end
      stall_d = stall;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (4) @(negedge clk);
    chk(stall == 1'b0, "R1", "stall in reset", {31'd0, stall}, 32'd0);
    chk(quotient == '0, "R1", "quotient in reset", quotient, 32'd0);
    chk(remainder == '0, "R1", "remainder in reset", remainder, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(stall == 1'b0, "R1", "stall after reset", {31'd0, stall}, 32'd0);
    chk(quotient == '0 && remainder == '0, "R1", "results after reset",
        quotient | remainder, 32'd0);

    // R9: idle with no start
    repeat (10) @(negedge clk);
    chk(stall == 1'b0, "R9", "idle stall", {31'd0, stall}, 32'd0);

    // R3: four sign combinations
    do_div(32'd42, 32'd13, "R3");
    do_div(-32'sd42, 32'd13, "R3");
    do_div(32'd42, -32'sd13, "R3");
    do_div(-32'sd42, -32'sd13, "R3");
    do_div(32'd39, 32'd13, "R3");
    do_div(32'd5, 32'd13, "R3");
    do_div(-32'sd5, 32'd13, "R3");

    // R4: large magnitudes
    do_div(32'h7FFF_FFFF, 32'd3, "R4");
    do_div(32'h8000_0000, 32'd7, "R4");
    do_div(32'h8000_0000, 32'h8000_0000, "R4");
    do_div(32'h7FFF_FFFF, 32'h8000_0000, "R4");
    do_div(32'h8000_0001, 32'h7FFF_FFFF, "R4");
    do_div(32'd123456789, -32'sd98765, "R4");

    // R6 and R7
    do_div(32'h8000_0000, 32'hFFFF_FFFF, "R6");
    do_div(32'd1000, 32'd0, "R7");
    do_div(-32'sd1000, 32'd0, "R7");
    do_div(32'd0, 32'd0, "R7");

    // R5: start pulse in the middle of a running division is ignored
    do_div(32'd100, 32'd7, "R5");
    repeat (5) @(negedge clk);
    start = 1'b1; dividend = 32'd999; divisor = 32'd2;
    @(negedge clk);
    start = 1'b0;
    while (stall) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(stall == 1'b0, "R5", "no division after ignored start",
        {31'd0, stall}, 32'd0);

    // R8: results held while idle
    repeat (20) @(negedge clk);
    chk(quotient == last_q, "R8", "quotient hold", quotient, last_q);
    chk(remainder == last_r, "R8", "remainder hold", remainder, last_r);

    // R4: random operands
    for (int i = 0; i < 40; i++) begin
      ra = $urandom();
      rb = $urandom();
      if (i % 4 == 1) rb = rb >> 20;
      if (i % 4 == 2) rb = -(rb >> 24);
      do_div(ra, rb, "R4");
    end

    @(negedge clk);
    while (stall || sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule